// File: doc/BRIEF.md
# Strided Lane Scratchpad Access Port

This block is a scratch memory of 64 rows, each 16 words of 32 bits. A 16-wide SIMD processor reads and writes it one vector at a time. Every access moves 16 elements, one for each lane. A setup strobe, kept separately for the read side and the write side, loads an access description. The description holds the element size (8, 16 or 32 bit), a laned or packed layout for sub-word elements, a horizontal or vertical orientation, a start address and an address increment. A read setup also holds the number of vectors that will be read.

After a setup, each write strobe merges the 16 lane elements into the memory under byte enables. Each read strobe returns 16 zero-extended elements on the following cycle. Both pointers then step by their own increment, modulo the 8-bit address field. Reads honour a setup latency: a read accepted one or two cycles after a read setup gets a zero vector flagged as invalid. A read that goes past the vector count is rejected with an error pulse. So is a new read setup that arrives while vectors are still owed.

Top module: `lane_scratch_mem`

## Requirements
- R1: With 32-bit size in horizontal orientation, lane i reads or writes word i of row addr[7:2]; addr[1:0] is ignored.
- R2: In laned mode, lane i touches only word i. For 8-bit elements it uses byte addr[1:0] of that word; for 16-bit elements it uses halfword addr[0]. The other bytes of the word keep their contents.
- R3: In packed mode with 8-bit elements, lane i goes to word 4*addr[1:0] + i/4, byte i%4. With 16-bit elements, lane i goes to word 8*addr[0] + i/2, halfword i%2.
- R4: In vertical orientation the word index k that R1 to R3 give becomes a row offset. The access uses row 16*addr[7:6] + k in word column addr[5:2], with the same byte or halfword position.
- R5: Each accepted access adds its side's stride to that side's address, modulo 256. The read and write pointers advance independently.
- R6: Size code 0 selects 8-bit elements, 1 selects 16-bit, and 2 or 3 select 32-bit. Read elements appear zero-extended in the low bits of each 32-bit lane of rdData (lane i at bits 32i+31..32i).
- R7: A read accepted at the first or second clock edge after a read setup returns rdEarly high with an all-zero rdData. It still counts as a vector and still steps the address. From the third edge on, reads return memory data with rdEarly low.
- R8: rdValid is high for exactly the cycle after each accepted read, and only then.
- R9: A read strobe while no vectors remain is rejected: rdValid stays low and rdErr pulses high on the next cycle. Reset leaves zero vectors remaining.
- R10: A read setup that arrives while vectors remain pulses rdErr on the next cycle and replaces the old setup.
- R11: A setup strobe in the same cycle as an access on the same side takes priority, and that access is dropped.
- R12: During and right after reset, rdValid, rdEarly and rdErr are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| setupRd | input | 1 | Load read-side access description |
| setupWr | input | 1 | Load write-side access description |
| cfgSize | input | 2 | Element size code for the setup |
| cfgLaned | input | 1 | 1 = laned, 0 = packed sub-word layout |
| cfgHoriz | input | 1 | 1 = horizontal, 0 = vertical orientation |
| cfgAddr | input | 8 | Start address for the setup |
| cfgStride | input | 8 | Address increment per access |
| cfgNum | input | 4 | Vector count for a read setup |
| wrEn | input | 1 | Write one vector |
| wrData | input | 512 | Lane elements to write, lane i in bits 32i+31..32i |
| rdEn | input | 1 | Read one vector |
| rdData | output | 512 | Lane elements read, zero-extended |
| rdValid | output | 1 | rdData holds a read result |
| rdEarly | output | 1 | The read came too soon after setup; data is zero |
| rdErr | output | 1 | Over-read or premature read setup detected |

## Verification
The assertions assume that reset is held for several cycles with every strobe low. This keeps history terms from seeing undriven inputs. They also assume that setup and access strobes are sampled cleanly at clock edges. The bench drives all inputs on the falling edge and keeps them at zero through reset. Before any read it fills the whole memory with known data, so no read can return an undefined word. The random phase drains every read setup before the next one. This leaves rdErr to the directed cases that target it.

// File: rtl/lane_scratch_pkg.sv
package lane_scratch_pkg;

  localparam int LANES   = 16;
  localparam int WORD_W  = 32;
  localparam int BYTES   = WORD_W / 8;
  localparam int ROWS    = 64;
  localparam int ROW_W   = $clog2(ROWS);
  localparam int COL_W   = $clog2(LANES);
  localparam int ADDR_W  = ROW_W + 2;
  localparam int NUM_W   = 4;
  localparam int LAT     = 3;
  localparam int SINCE_W = $clog2(LAT);
  localparam int SHIFT_W = $clog2(WORD_W);
  localparam int BUS_W   = LANES * WORD_W;

  // Access description held per side
  typedef struct packed {
    logic [1:0] size;   // 0: 8 bit, 1: 16 bit, 2/3: 32 bit
    logic       laned;
    logic       horiz;
  } accCfg_t;

  // Where one lane lands in the array
  typedef struct packed {
    logic [ROW_W-1:0]   row;
    logic [COL_W-1:0]   col;
    logic [BYTES-1:0]   be;
    logic [SHIFT_W-1:0] shift;
  } laneLoc_t;

  // Control to datapath strobes
  typedef struct packed {
    logic doWr;
    logic doRd;
    logic rdEarly;
  } strobe_t;

  function automatic laneLoc_t mapLane(accCfg_t c, logic [ADDR_W-1:0] a,
                                       logic [COL_W-1:0] ln);
    laneLoc_t l;
    logic [COL_W-1:0] k;
    logic [1:0] pos;
    k   = ln;
    pos = 2'd0;
    if (!c.size[1]) begin
      if (c.size[0]) begin
        if (c.laned) begin
          pos = {1'b0, a[0]};
        end else begin
          k   = {a[0], 3'b000} + {1'b0, ln[3:1]};
          pos = {1'b0, ln[0]};
        end
      end else begin
        if (c.laned) begin
          pos = a[1:0];
        end else begin
          k   = {a[1:0], 2'b00} + {2'b00, ln[3:2]};
          pos = ln[1:0];
        end
      end
    end
    if (c.horiz) begin
      l.row = a[ADDR_W-1:2];
      l.col = k;
    end else begin
      l.row = {a[ADDR_W-1:ADDR_W-2], k};
      l.col = a[ADDR_W-3:2];
    end
    if (c.size[1]) begin
      l.be    = '1;
      l.shift = '0;
    end else if (c.size[0]) begin
      l.be    = pos[0] ? 4'b1100 : 4'b0011;
      l.shift = {pos[0], 4'b0000};
    end else begin
      l.be    = 4'b0001 << pos;
      l.shift = {pos, 3'b000};
    end
    return l;
  endfunction

  function automatic logic [WORD_W-1:0] byteMask(logic [BYTES-1:0] be);
    logic [WORD_W-1:0] m;
    for (int b = 0; b < BYTES; b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction

endpackage

// File: rtl/lane_scratch_ctrl.sv
module lane_scratch_ctrl
  import lane_scratch_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              setupRd,
  input  logic              setupWr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  accCfg_t           cfgIn,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [ADDR_W-1:0] strideIn,
  input  logic [NUM_W-1:0]  numIn,
  output strobe_t           stb,
  output accCfg_t           wrCfg,
  output accCfg_t           rdCfg,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rdErr
);

  localparam logic [SINCE_W-1:0] SINCE_MAX = SINCE_W'(LAT - 1);

  accCfg_t             wrCfgQ, rdCfgQ;
  logic [ADDR_W-1:0]   wrAddrQ, rdAddrQ, wrStrideQ, rdStrideQ;
  logic [NUM_W-1:0]    remainQ;
  logic [SINCE_W-1:0]  sinceQ;
  logic                rdErrQ;
  logic                wrOk, rdOk, owed;

  assign owed = (remainQ != '0);
  assign wrOk = wrEn & ~setupWr;
  assign rdOk = rdEn & ~setupRd & owed;

  always_comb begin
    stb.doWr    = wrOk;
    stb.doRd    = rdOk;
    stb.rdEarly = (sinceQ < SINCE_MAX);
  end

  // Write side pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrCfgQ    <= '0;
      wrAddrQ   <= '0;
      wrStrideQ <= '0;
    end else if (setupWr) begin
      wrCfgQ    <= cfgIn;
      wrAddrQ   <= addrIn;
      wrStrideQ <= strideIn;
    end else if (wrOk) begin
      wrAddrQ   <= wrAddrQ + wrStrideQ;
    end
  end

  // Read side pointer, vector count and setup latency
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdCfgQ    <= '0;
      rdAddrQ   <= '0;
      rdStrideQ <= '0;
      remainQ   <= '0;
      sinceQ    <= SINCE_MAX;
    end else if (setupRd) begin
      rdCfgQ    <= cfgIn;
      rdAddrQ   <= addrIn;
      rdStrideQ <= strideIn;
      remainQ   <= numIn;
      sinceQ    <= '0;
    end else begin
      if (sinceQ != SINCE_MAX) sinceQ <= sinceQ + 1'b1;
      if (rdOk) begin
        rdAddrQ <= rdAddrQ + rdStrideQ;
        remainQ <= remainQ - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdErrQ <= 1'b0;
    else       rdErrQ <= (setupRd & owed) | (rdEn & ~setupRd & ~owed);
  end

  assign wrCfg  = wrCfgQ;
  assign rdCfg  = rdCfgQ;
  assign wrAddr = wrAddrQ;
  assign rdAddr = rdAddrQ;
  assign rdErr  = rdErrQ;

endmodule

// File: rtl/lane_scratch_data.sv
module lane_scratch_data
  import lane_scratch_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  accCfg_t           wrCfg,
  input  accCfg_t           rdCfg,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [BUS_W-1:0]  wrData,
  output logic [BUS_W-1:0]  rdData,
  output logic              rdValid,
  output logic              rdEarly
);

  logic [WORD_W-1:0] mem [ROWS][LANES];

  laneLoc_t          wrLoc     [LANES];
  laneLoc_t          rdLoc     [LANES];
  logic [WORD_W-1:0] wrAligned [LANES];
  logic [WORD_W-1:0] rdElem    [LANES];
  logic [WORD_W-1:0] rdLaneQ   [LANES];

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [WORD_W-1:0] rawWord;
    assign wrLoc[g]     = mapLane(wrCfg, wrAddr, COL_W'(g));
    assign wrAligned[g] = wrData[g*WORD_W +: WORD_W] << wrLoc[g].shift;
    assign rdLoc[g]     = mapLane(rdCfg, rdAddr, COL_W'(g));
    assign rawWord      = mem[rdLoc[g].row][rdLoc[g].col];
    assign rdElem[g]    = (rawWord & byteMask(rdLoc[g].be)) >> rdLoc[g].shift;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          rdLaneQ[g] <= '0;
      else if (stb.doRd)  rdLaneQ[g] <= stb.rdEarly ? '0 : rdElem[g];
    end

    assign rdData[g*WORD_W +: WORD_W] = rdLaneQ[g];
  end

  // Byte-enabled merge of all lanes into the array
  always_ff @(posedge clk) begin
    if (stb.doWr) begin
      for (int i = 0; i < LANES; i++) begin
        for (int b = 0; b < BYTES; b++) begin
          if (wrLoc[i].be[b])
            mem[wrLoc[i].row][wrLoc[i].col][b*8 +: 8] <= wrAligned[i][b*8 +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdEarly <= 1'b0;
    end else begin
      rdValid <= stb.doRd;
      rdEarly <= stb.doRd & stb.rdEarly;
    end
  end

endmodule

// File: rtl/lane_scratch_mem.sv
module lane_scratch_mem
  import lane_scratch_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              setupRd,
  input  logic              setupWr,
  input  logic [1:0]        cfgSize,
  input  logic              cfgLaned,
  input  logic              cfgHoriz,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [ADDR_W-1:0] cfgStride,
  input  logic [NUM_W-1:0]  cfgNum,
  input  logic              wrEn,
  input  logic [BUS_W-1:0]  wrData,
  input  logic              rdEn,
  output logic [BUS_W-1:0]  rdData,
  output logic              rdValid,
  output logic              rdEarly,
  output logic              rdErr
);

  accCfg_t           cfgIn, wrCfg, rdCfg;
  strobe_t           stb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  always_comb begin
    cfgIn.size  = cfgSize;
    cfgIn.laned = cfgLaned;
    cfgIn.horiz = cfgHoriz;
  end

  lane_scratch_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .setupRd  (setupRd),
    .setupWr  (setupWr),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .cfgIn    (cfgIn),
    .addrIn   (cfgAddr),
    .strideIn (cfgStride),
    .numIn    (cfgNum),
    .stb      (stb),
    .wrCfg    (wrCfg),
    .rdCfg    (rdCfg),
    .wrAddr   (wrAddr),
    .rdAddr   (rdAddr),
    .rdErr    (rdErr)
  );

  lane_scratch_data uData (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrCfg   (wrCfg),
    .rdCfg   (rdCfg),
    .wrAddr  (wrAddr),
    .rdAddr  (rdAddr),
    .wrData  (wrData),
    .rdData  (rdData),
    .rdValid (rdValid),
    .rdEarly (rdEarly)
  );

endmodule

// File: rtl/lane_scratch_chk.sv
module lane_scratch_chk
  import lane_scratch_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             setupRd,
  input logic             rdEn,
  input logic [BUS_W-1:0] rdData,
  input logic             rdValid,
  input logic             rdEarly,
  input logic             rdErr
);

  // R8
  valid_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(rdEn));

  // R7
  early_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEarly |-> (rdValid && rdData == '0));

  // R9 R10
  err_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |-> $past(rdEn || setupRd));

  // R11
  setup_drops_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    setupRd |=> !rdValid);

  // R7
  first_read_early_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(setupRd) && rdEn && !setupRd) |=> (rdEarly || !rdValid));

endmodule

bind lane_scratch_mem lane_scratch_chk uChk (.*);

// File: tb/lane_scratch_mem_test.sv
module lane_scratch_mem_test;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         setupRd = 0, setupWr = 0, cfgLaned = 0, cfgHoriz = 0;
  logic [1:0]   cfgSize = 0;
  logic [7:0]   cfgAddr = 0, cfgStride = 0;
  logic [3:0]   cfgNum = 0;
  logic         wrEn = 0, rdEn = 0;
  logic [511:0] wrData = '0;
  logic [511:0] rdData;
  logic         rdValid, rdEarly, rdErr;

  lane_scratch_mem uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] refMem [64][16];
  int checks = 0, fails = 0;
  bit done = 0;

  bit [1:0] wSize, rSize;
  bit       wLaned, wHoriz, rLaned, rHoriz;
  bit [7:0] wAddr, wStride, rAddr, rStride;
  int       rRemain = 0;

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got %h exp %h", req, act, exp);
    end
  endtask

  // Lane placement, worked out from the requirement text
  function automatic void locate(input bit [1:0] sz, input bit laned, input bit horiz,
                                 input bit [7:0] a, input int lane,
                                 output int row, output int col, output int pos, output int width);
    int per, idx, sel;
    width = sz[1] ? 32 : (sz[0] ? 16 : 8);
    per   = 32 / width;
    sel   = a[1:0];
    if (per == 1 || laned) begin
      idx = lane;
      pos = (per == 1) ? 0 : (sel % per);
    end else begin
      idx = (sel % per) * (16 / per) + lane / per;
      pos = lane % per;
    end
    if (horiz) begin
      row = a[7:2];
      col = idx;
    end else begin
      row = a[7:6] * 16 + idx;
      col = a[5:2];
    end
  endfunction

  function automatic logic [511:0] expRead(input bit [1:0] sz, input bit laned, input bit horiz, input bit [7:0] a);
    logic [511:0] v;
    int row, col, pos, width;
    longint unsigned m;
    for (int i = 0; i < 16; i++) begin
      locate(sz, laned, horiz, a, i, row, col, pos, width);
      m = (64'd1 << width) - 1;
      v[i*32 +: 32] = 32'((longint'(refMem[row][col]) >> (pos*width)) & m);
    end
    return v;
  endfunction

  task automatic modelWrite(input logic [511:0] d);
    int row, col, pos, width;
    longint unsigned m, w;
    for (int i = 0; i < 16; i++) begin
      locate(wSize, wLaned, wHoriz, wAddr, i, row, col, pos, width);
      m = ((64'd1 << width) - 1) << (pos*width);
      w = longint'(refMem[row][col]);
      w = (w & ~m) | ((longint'(d[i*32 +: 32]) << (pos*width)) & m);
      refMem[row][col] = 32'(w);
    end
  endtask

  task automatic setW(input bit [1:0] sz, input bit l, input bit h, input bit [7:0] a, input bit [7:0] s);
    setupWr = 1; cfgSize = sz; cfgLaned = l; cfgHoriz = h; cfgAddr = a; cfgStride = s;
    @(negedge clk);
    setupWr = 0;
    wSize = sz; wLaned = l; wHoriz = h; wAddr = a; wStride = s;
  endtask

  task automatic wr(input logic [511:0] d);
    wrEn = 1; wrData = d;
    @(negedge clk);
    wrEn = 0;
    modelWrite(d);
    wAddr = wAddr + wStride;
  endtask

  task automatic setR(input bit [1:0] sz, input bit l, input bit h, input bit [7:0] a,
                      input bit [7:0] s, input int num, input bit settle);
    bit owed;
    owed = (rRemain != 0);
    setupRd = 1; cfgSize = sz; cfgLaned = l; cfgHoriz = h; cfgAddr = a; cfgStride = s;
    cfgNum = 4'(num);
    @(negedge clk);
    setupRd = 0;
    // R10: premature setup flags an error
    chk(rdErr === owed && rdValid === 1'b0, "R10 setup error flag", {rdErr, rdValid}, {owed, 1'b0});
    rSize = sz; rLaned = l; rHoriz = h; rAddr = a; rStride = s; rRemain = num;
    if (settle) repeat (2) @(negedge clk);
  endtask

  task automatic rd(input string req, input bit expEarly);
    logic [511:0] e;
    bit had;
    had = (rRemain != 0);
    e = (had && !expEarly) ? expRead(rSize, rLaned, rHoriz, rAddr) : '0;
    rdEn = 1;
    @(negedge clk);
    rdEn = 0;
    if (had) begin
      // R8 valid one cycle after the read
      chk(rdValid === 1'b1 && rdEarly === expEarly && rdErr === 1'b0,
          {req, " R8 status"}, {rdValid, rdEarly, rdErr}, {1'b1, expEarly, 1'b0});
      chk(rdData === e, req, rdData, e);
      rAddr = rAddr + rStride;
      rRemain--;
    end else begin
      // R9 over-read
      chk(rdValid === 1'b0 && rdErr === 1'b1, {req, " R9 over-read"}, {rdValid, rdErr}, 2'b01);
    end
  endtask

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [511:0] laneIdx(input logic [31:0] base);
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = base + 32'(i * 32'h01010101);
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R12 reset state
    chk(rdValid === 1'b0 && rdEarly === 1'b0 && rdErr === 1'b0, "R12 in reset",
        {rdValid, rdEarly, rdErr}, '0);
    rstN = 1;
    @(negedge clk);
    chk(rdValid === 1'b0 && rdEarly === 1'b0 && rdErr === 1'b0, "R12 after reset",
        {rdValid, rdEarly, rdErr}, '0);
    // R12 zero vectors owed after reset, so the read is rejected (R9)
    rd("R12 read before setup", 1'b0);

    // Fill memory, 32-bit horizontal, one row per step (R1, R5)
    setW(2'd2, 0, 1, 8'h00, 8'h04);
    for (int r = 0; r < 64; r++) wr(rnd512());

    // R1 horizontal word, sel bits ignored
    setW(2'd2, 1, 1, 8'd23, 8'd0);
    wr(laneIdx(32'hA0000000));
    setR(2'd2, 0, 1, 8'd20, 8'd0, 1, 1);
    rd("R1 horizontal 32", 1'b0);

    // R2 laned byte 1 in row 6, laned halfword 1 in row 7
    setW(2'd0, 1, 1, 8'd25, 8'd0);
    wr(rnd512());
    setW(2'd1, 1, 1, 8'd29, 8'd0);
    wr(rnd512());
    setR(2'd2, 0, 1, 8'd24, 8'd4, 2, 1);
    rd("R2 laned byte merge", 1'b0);
    rd("R2 laned half merge", 1'b0);

    // R3 packed bytes block 2 in row 8, packed halves block 1 in row 9
    setW(2'd0, 0, 1, 8'd34, 8'd0);
    wr(laneIdx(32'h00000011));
    setW(2'd1, 0, 1, 8'd37, 8'd0);
    wr(laneIdx(32'h00002222));
    setR(2'd2, 0, 1, 8'd32, 8'd4, 2, 1);
    rd("R3 packed byte", 1'b0);
    rd("R3 packed half", 1'b0);

    // R4 vertical word column 3 rows 16..31, vertical packed bytes column 5 block 1 rows 32..
    setW(2'd2, 0, 0, 8'h4C, 8'd0);
    wr(laneIdx(32'h40000000));
    setW(2'd0, 0, 0, 8'h95, 8'd0);
    wr(rnd512());
    setR(2'd2, 0, 0, 8'h4C, 8'd0, 1, 1);
    rd("R4 vertical 32", 1'b0);
    setR(2'd2, 0, 0, 8'h94, 8'd0, 1, 1);
    rd("R4 vertical packed", 1'b0);
    // R6 zero-extended 8-bit and 16-bit reads
    setR(2'd0, 0, 0, 8'h95, 8'd0, 1, 1);
    rd("R6 read packed byte", 1'b0);
    setR(2'd1, 1, 1, 8'd29, 8'd0, 1, 1);
    rd("R6 read laned half", 1'b0);

    // R5 stride stepping and wrap modulo 256
    setW(2'd2, 0, 1, 8'd40, 8'd4);
    for (int v = 0; v < 3; v++) wr(rnd512());
    setR(2'd2, 0, 1, 8'd40, 8'd4, 3, 1);
    for (int v = 0; v < 3; v++) rd("R5 stride", 1'b0);
    setW(2'd2, 0, 1, 8'hFC, 8'd8);
    wr(rnd512());
    wr(rnd512());
    setR(2'd2, 0, 1, 8'hFC, 8'd8, 2, 1);
    rd("R5 wrap first", 1'b0);
    rd("R5 wrap second", 1'b0);

    // R7 two early reads then a real one
    setR(2'd2, 0, 1, 8'd40, 8'd4, 3, 0);
    rd("R7 early edge 1", 1'b1);
    rd("R7 early edge 2", 1'b1);
    rd("R7 edge 3 data", 1'b0);
    // R9 one too many
    rd("R9 extra read", 1'b0);

    // R10 setup with one vector still owed
    setR(2'd2, 0, 1, 8'd0, 8'd4, 2, 1);
    rd("R10 partial", 1'b0);
    setR(2'd2, 0, 1, 8'd8, 8'd4, 1, 1);
    rd("R10 after replace", 1'b0);

    // R11 write dropped when setup shares its cycle
    setupWr = 1; cfgSize = 2'd2; cfgLaned = 0; cfgHoriz = 1; cfgAddr = 8'd48; cfgStride = 8'd0;
    wrEn = 1; wrData = '1;
    @(negedge clk);
    setupWr = 0; wrEn = 0;
    wSize = 2'd2; wLaned = 0; wHoriz = 1; wAddr = 8'd48; wStride = 8'd0;
    setR(2'd2, 0, 1, 8'd48, 8'd0, 1, 1);
    rd("R11 write dropped", 1'b0);
    // R11 read dropped when setup shares its cycle
    setupRd = 1; cfgNum = 4'd1; cfgAddr = 8'd48; rdEn = 1;
    @(negedge clk);
    setupRd = 0; rdEn = 0;
    chk(rdValid === 1'b0 && rdErr === 1'b0, "R11 read dropped", {rdValid, rdErr}, 2'b00);
    rSize = 2'd2; rLaned = 0; rHoriz = 1; rAddr = 8'd48; rStride = 8'd0; rRemain = 1;
    repeat (2) @(negedge clk);
    rd("R11 read after drop", 1'b0);

    // Random mix across sizes, layouts, orientations and strides (R1-style checks per read)
    for (int it = 0; it < 300; it++) begin
      bit [1:0] sz;
      bit l, h;
      bit [7:0] a, s;
      int n;
      sz = 2'($urandom % 4); l = 1'($urandom); h = 1'($urandom);
      a = 8'($urandom); s = 8'($urandom % 16);
      n = 1 + int'($urandom % 4);
      if ($urandom % 2) begin
        setW(sz, l, h, a, s);
        for (int v = 0; v < n; v++) wr(rnd512());
      end else begin
        setR(sz, l, h, a, s, n, 1);
        for (int v = 0; v < n; v++) rd("R4 R6 random read", 1'b0);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule